// File: doc/BRIEF.md
# Dual-Register DDS Waveform Core

A numerically controlled oscillator for frequency and phase keying. A 28-bit phase accumulator adds a frequency tuning word on every clock. Two tuning words and two 12-bit phase offsets are held in registers, and select inputs pick the active word of each pair. Keying is done by toggling a select input. A toggle changes the step or the offset on the next edge. The accumulator is never reset by it, so the waveform keeps its phase.

The offset phase is the top 12 accumulator bits plus the chosen offset. It drives one of two waveforms. The sine waveform is a 10-bit two's complement amplitude built from a quarter-wave table with 1024 entries. The table is computed when the design is elaborated. The ramp waveform is the offset phase itself. A separate sign-bit output follows the top accumulator bit, or the bit just below it, which runs at twice the rate. Two sleep controls can be used alone or together. One freezes the accumulator. The other forces the amplitude to zero while the sign bit keeps toggling.

Top module: `dds_core`

## Requirements
- R1: A synchronous reset clears the accumulator and all four registers, and drives `dout` and `sign_out` to 0 after the reset edge.
- R2: On each edge with `clk_off` low, the accumulator adds the selected tuning word, modulo 2^28.
- R3: `fsel` = 0 selects tuning word 0 and `fsel` = 1 selects tuning word 1. A change takes effect on the next edge and does not reset the accumulator.
- R4: The offset phase is accumulator bits [27:16] plus the selected offset register, modulo 4096. `psel` = 0 selects offset 0 and `psel` = 1 selects offset 1.
- R5: With `ramp_mode` = 0, `dout` is round(511·sin(2π·(p+0.5)/4096)) within ±1, where p is the offset phase. `dout` is two's complement and never equals -512.
- R6: With `ramp_mode` = 1, `dout` equals bits [11:2] of the offset phase.
- R7: With `sign_half` = 0, `sign_out` is accumulator bit 27. With `sign_half` = 1, it is bit 26.
- R8: While `clk_off` is high, the accumulator does not change.
- R9: While `dac_off` is high, `dout` is 0 and `sign_out` still follows the accumulator. Setting both `clk_off` and `dac_off` gives a zero output with a frozen accumulator.
- R10: A write with `wr_en` = 1 loads `wr_data` into the register chosen by `wr_addr`: 0 is tuning word 0, 1 is tuning word 1, 2 is offset 0 (bits [11:0]), and 3 is offset 1 (bits [11:0]). The write leaves the accumulator untouched, and the new value is first used on the following edge.
- R11: `dout` and `sign_out` are registered. After an edge they reflect the accumulator, registers and controls as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register to write (0/1 tuning, 2/3 offset) |
| wr_data | input | 28 | Write data |
| fsel | input | 1 | Active tuning word select |
| psel | input | 1 | Active phase offset select |
| ramp_mode | input | 1 | 1 = ramp waveform, 0 = sine |
| sign_half | input | 1 | 1 = sign bit from accumulator bit 26, 0 = bit 27 |
| clk_off | input | 1 | Freeze the accumulator |
| dac_off | input | 1 | Force the amplitude to zero |
| dout | output | 10 | Amplitude word |
| sign_out | output | 1 | Sign-bit output |

## Verification
Directed runs come first.
- A step of exactly one phase unit in ramp mode shows whether the accumulator advances once per edge with a one-cycle output delay.
- Toggling `fsel` and `psel` between unlike values separates a phase-continuous switch from one that restarts or applies the wrong register.
- Each sleep control is held alone and then together, which separates a frozen accumulator from a zeroed amplitude.

Random writes, selects and modes then sweep the sine across all four quadrants. Mirroring or sign faults appear there as amplitude errors. Flipping the sign-bit source at the same time distinguishes bit 27 from bit 26.

// File: rtl/dds_core.sv
module dds_core #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int AMP_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             fsel,
  input  logic             psel,
  input  logic             ramp_mode,
  input  logic             sign_half,
  input  logic             clk_off,
  input  logic             dac_off,
  output logic [AMP_W-1:0] dout,
  output logic             sign_out
);
  localparam int QA   = PH_W - 2;
  localparam int QN   = 1 << QA;
  localparam int MAXA = (1 << (AMP_W - 1)) - 1;

  function automatic logic [AMP_W-2:0] qsin(input int i);
    longint s, x, t, a;
    s = longint'(1) << 30;
    x = (longint'(2 * i + 1) * 64'sd3373259426) / longint'(4 * QN);
    t = x;
    a = x;
    for (int k = 1; k <= 6; k++) begin
      t = (t * x) / s;
      t = (t * x) / s;
      t = -t / longint'((2 * k) * (2 * k + 1));
      a = a + t;
    end
    a = (a * longint'(MAXA) + s / 2) / s;
    return a[AMP_W-2:0];
  endfunction

  logic [AMP_W-2:0] qtab [QN];
  for (genvar g = 0; g < QN; g++) begin : g_tab
    assign qtab[g] = qsin(g);
  end

  logic [ACC_W-1:0] acc, f0, f1;
  logic [PH_W-1:0]  p0, p1;

  wire [ACC_W-1:0] fword = fsel ? f1 : f0;
  wire [PH_W-1:0]  ph    = acc[ACC_W-1 -: PH_W] + (psel ? p1 : p0);
  wire [QA-1:0]    qidx  = ph[PH_W-2] ? ~ph[QA-1:0] : ph[QA-1:0];
  wire [AMP_W-2:0] mag   = qtab[qidx];
  wire [AMP_W-1:0] sine  = ph[PH_W-1] ? -{1'b0, mag} : {1'b0, mag};
  wire [AMP_W-1:0] ramp  = ph[PH_W-1 -: AMP_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      f0       <= '0;
      f1       <= '0;
      p0       <= '0;
      p1       <= '0;
      dout     <= '0;
      sign_out <= 1'b0;
    end else begin
      if (!clk_off) acc <= acc + fword;
      if (wr_en) begin
        case (wr_addr)
          2'd0: f0 <= wr_data;
          2'd1: f1 <= wr_data;
          2'd2: p0 <= wr_data[PH_W-1:0];
          default: p1 <= wr_data[PH_W-1:0];
        endcase
      end
      dout     <= dac_off ? '0 : (ramp_mode ? ramp : sine);
      sign_out <= sign_half ? acc[ACC_W-2] : acc[ACC_W-1];
    end
  end
endmodule

module dds_core_chk #(
  parameter int ACC_W = 28,
  parameter int AMP_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             ramp_mode,
  input logic             sign_half,
  input logic             clk_off,
  input logic             dac_off,
  input logic [ACC_W-1:0] acc,
  input logic [AMP_W-1:0] dout,
  input logic             sign_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc == '0 && dout == '0 && !sign_out));
  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    clk_off |=> acc == $past(acc));
  // R9
  dac_zero_chk: assert property (@(posedge clk) disable iff (rst)
    dac_off |=> dout == '0);
  // R7
  sign_msb_chk: assert property (@(posedge clk) disable iff (rst)
    !sign_half |=> sign_out == $past(acc[ACC_W-1]));
  // R7
  sign_half_chk: assert property (@(posedge clk) disable iff (rst)
    sign_half |=> sign_out == $past(acc[ACC_W-2]));
  // R5
  sine_range_chk: assert property (@(posedge clk) disable iff (rst)
    (!ramp_mode && !dac_off) |=> dout != {1'b1, {(AMP_W-1){1'b0}}});
endmodule

bind dds_core dds_core_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst(rst), .ramp_mode(ramp_mode), .sign_half(sign_half),
  .clk_off(clk_off), .dac_off(dac_off), .acc(acc), .dout(dout),
  .sign_out(sign_out)
);

// File: tb/dds_core_test.sv
module dds_core_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst, wr_en, fsel, psel, ramp_mode, sign_half, clk_off, dac_off;
  logic [1:0]  wr_addr;
  logic [27:0] wr_data;
  logic [9:0]  dout;
  logic        sign_out;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [27:0] m_acc, m_f0, m_f1;
  logic [11:0] m_p0, m_p1;

  always #(PERIOD/2) clk = ~clk;

  dds_core uut (.*);

  function automatic int exp_sine(input int p);
    real a;
    a = 2.0 * 3.14159265358979 * (real'(p) + 0.5) / 4096.0;
    return int'(511.0 * $sin(a));
  endfunction

  task automatic check(input string tag, input int act, input int exp, input int tol);
    int d;
    tests++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [11:0] ph;
    int ed, tol;
    logic es;
    ph  = m_acc[27:16] + (psel ? m_p1 : m_p0);
    tol = 0;
    if (rst) begin
      ed = 0; es = 1'b0;
    end else begin
      if (dac_off) ed = 0;
      else if (ramp_mode) ed = int'(ph[11:2]);
      else begin ed = exp_sine(int'(ph)); tol = 1; end
      es = sign_half ? m_acc[26] : m_acc[27];
    end
    @(posedge clk);
    if (rst) begin
      m_acc = '0; m_f0 = '0; m_f1 = '0; m_p0 = '0; m_p1 = '0;
    end else begin
      if (!clk_off) m_acc = m_acc + (fsel ? m_f1 : m_f0);
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_f0 = wr_data;
          2'd1: m_f1 = wr_data;
          2'd2: m_p0 = wr_data[11:0];
          default: m_p1 = wr_data[11:0];
        endcase
      end
    end
    #1;
    if (ramp_mode || dac_off || rst) check(tag, int'(dout), ed, tol);
    else check(tag, int'($signed(dout)), ed, tol);
    check({tag, " R7 sign"}, int'(sign_out), int'(es), 0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [27:0] d, input string tag);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(tag);
    wr_en = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; fsel = 0; psel = 0;
    ramp_mode = 0; sign_half = 0; clk_off = 0; dac_off = 0;
    m_acc = '0; m_f0 = '0; m_f1 = '0; m_p0 = '0; m_p1 = '0;
    repeat (3) step("R1 reset");
    rst = 1'b0;
    step("R1 after reset");

    ramp_mode = 1'b1;
    wr(2'd0, 28'h0010000, "R10 write f0");
    for (int i = 0; i < 6; i++) step("R2 ramp step");
    step("R11 latency");

    wr(2'd1, 28'h0040000, "R10 write f1 while running");
    fsel = 1'b1;
    for (int i = 0; i < 5; i++) step("R3 fsel=1");
    fsel = 1'b0;
    for (int i = 0; i < 3; i++) step("R3 fsel=0");

    wr(2'd2, 28'hFFFF123, "R10 write p0");
    step("R4 psel=0");
    wr(2'd3, 28'h0000800, "R10 write p1");
    psel = 1'b1;
    for (int i = 0; i < 3; i++) step("R4 psel=1");
    step("R6 ramp");

    clk_off = 1'b1;
    for (int i = 0; i < 4; i++) step("R8 freeze");
    clk_off = 1'b0; dac_off = 1'b1; sign_half = 1'b1;
    wr(2'd0, 28'h1000000, "R10 write f0 fast");
    psel = 1'b0; fsel = 1'b0;
    for (int i = 0; i < 8; i++) step("R9 dac off");
    clk_off = 1'b1;
    for (int i = 0; i < 3; i++) step("R9 full sleep");
    clk_off = 1'b0; dac_off = 1'b0; ramp_mode = 1'b0; sign_half = 1'b0;

    wr(2'd0, 28'h0010000, "R10 f0 unit");
    for (int i = 0; i < 4200; i++) step("R5 sine sweep");

    for (int i = 0; i < 3000; i++) begin
      wr_en     = ($urandom % 8) == 0;
      wr_addr   = 2'($urandom);
      wr_data   = 28'($urandom);
      fsel      = 1'($urandom);
      psel      = 1'($urandom);
      ramp_mode = ($urandom % 4) == 0;
      sign_half = 1'($urandom);
      clk_off   = ($urandom % 8) == 0;
      dac_off   = ($urandom % 8) == 0;
      if (dac_off) step("R9 random");
      else if (clk_off) step("R8 random");
      else if (wr_en) step("R10 random");
      else if (ramp_mode) step("R6 random");
      else step("R5 random");
    end
    wr_en = 1'b0;
    rst = 1'b1;
    step("R1 late reset");
    rst = 1'b0; ramp_mode = 1'b1;
    step("R1 registers cleared");
    summary();
  end
endmodule